// File: doc/BRIEF.md
# Rotating Permutation First-Stage Switch

This block is the first stage of a three-stage packet fabric. It has no buffers and it does no scheduling. It has `N_IN` cell inputs and `N_OUT` cell outputs, with `N_OUT >= N_IN`. In each time slot it joins every input to a different output, following a fixed pattern. Each input carries at most one fixed-size cell per slot. That cell has a valid flag, a destination tag and a payload. The cell leaves on its assigned output in the same slot, through combinational paths only.

A phase counter selects the pattern. The counter steps by one when the slot strobe is high and wraps at `N_OUT`. In slot `t`, input `g` drives output `(g + t) mod N_OUT`. Over `N_OUT` consecutive slots, each input therefore reaches every output once and spreads its load evenly across the next stage. Several instances released from reset on the same edge stay in a known common phase.

Top module: `rot_perm_stage`

## Requirements
- R1: While reset is asserted and right after it, the phase counter reads 0 and input g drives output g.
- R2: On each clock edge with `slot_i` high, the phase advances by one and wraps from `N_OUT-1` to 0. With `slot_i` low, the phase holds.
- R3: In phase t, output `(g + t) mod N_OUT` carries the valid flag of input g (zero-based) in the same cycle, with no register on the path.
- R4: The mapping is one-to-one in every phase. The number of valid outputs always equals the number of valid inputs.
- R5: An output that no input maps to in the current phase drives valid, tag and data to zero.
- R6: The tag and data of input g appear unchanged on the output it maps to.
- R7: Over `N_OUT` consecutive strobed slots, each input is connected to every output exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_i | input | 1 | Slot strobe; advances the phase |
| in_vld_i | input | N_IN | Per-input cell valid; bit g is input g |
| in_tag_i | input | N_IN*TAG_W | Destination tags; input g at bits [g*TAG_W +: TAG_W] |
| in_data_i | input | N_IN*DATA_W | Cell payloads; input g at bits [g*DATA_W +: DATA_W] |
| out_vld_o | output | N_OUT | Per-output cell valid; bit o is output o |
| out_tag_o | output | N_OUT*TAG_W | Output tags; output o at bits [o*TAG_W +: TAG_W] |
| out_data_o | output | N_OUT*DATA_W | Output payloads; output o at bits [o*DATA_W +: DATA_W] |
| phase_o | output | CNT_W | Current phase t, 0 to N_OUT-1 |

## Verification
The phase register is the only state in the block. If it is wrong, every output lane shows a rotated mapping in that same cycle, and the error is visible on the very next sample. A wrong wrap point shows up one slot after phase `N_OUT-1`, because cells land on outputs shifted by one. Faults in the lane selector show as a lost cell, a duplicated cell, or a cell on an output that should be idle. The bench covers every input valid mask across two full rotations, so each lane is checked in every phase.

// File: rtl/rps_pkg.sv
package rps_pkg;
  function automatic int unsigned phase_w(input int unsigned m);
    return (m > 1) ? $clog2(m) : 1;
  endfunction
endpackage

// File: rtl/rps_phase_ctr.sv
module rps_phase_ctr #(
  parameter int unsigned N_OUT = 5,
  parameter int unsigned CNT_W = rps_pkg::phase_w(N_OUT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_i,
  output logic [CNT_W-1:0] phase_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_OUT - 1);

  logic [CNT_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (slot_i) phase_q <= (phase_q == LAST) ? '0 : phase_q + CNT_W'(1);
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/rps_lane_sel.sv
module rps_lane_sel #(
  parameter int unsigned N_IN    = 4,
  parameter int unsigned N_OUT   = 5,
  parameter int unsigned OUT_IDX = 0,
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CNT_W   = rps_pkg::phase_w(N_OUT)
) (
  input  logic [CNT_W-1:0]       phase_i,
  input  logic [N_IN-1:0]        in_vld_i,
  input  logic [N_IN*TAG_W-1:0]  in_tag_i,
  input  logic [N_IN*DATA_W-1:0] in_data_i,
  output logic                   vld_o,
  output logic [TAG_W-1:0]       tag_o,
  output logic [DATA_W-1:0]      data_o
);
  localparam int unsigned SW = CNT_W + 1;
  localparam logic [SW-1:0] OIDX = SW'(OUT_IDX);
  localparam logic [SW-1:0] MOD  = SW'(N_OUT);

  logic [SW-1:0] src;

  // source input = (OUT_IDX - phase) mod N_OUT
  always_comb begin
    if ({1'b0, phase_i} <= OIDX) src = OIDX - {1'b0, phase_i};
    else                         src = OIDX + MOD - {1'b0, phase_i};
  end

  always_comb begin
    vld_o  = 1'b0;
    tag_o  = '0;
    data_o = '0;
    for (int g = 0; g < int'(N_IN); g++) begin
      if (src == SW'(g)) begin
        vld_o  = in_vld_i[g];
        tag_o  = in_tag_i[g*TAG_W +: TAG_W];
        data_o = in_data_i[g*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/rot_perm_stage.sv
module rot_perm_stage #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_OUT  = 5,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = rps_pkg::phase_w(N_OUT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    slot_i,
  input  logic [N_IN-1:0]         in_vld_i,
  input  logic [N_IN*TAG_W-1:0]   in_tag_i,
  input  logic [N_IN*DATA_W-1:0]  in_data_i,
  output logic [N_OUT-1:0]        out_vld_o,
  output logic [N_OUT*TAG_W-1:0]  out_tag_o,
  output logic [N_OUT*DATA_W-1:0] out_data_o,
  output logic [CNT_W-1:0]        phase_o
);
  if (N_OUT < N_IN) begin : g_bad_cfg
    $error("rot_perm_stage: N_OUT must be >= N_IN");
  end

  logic [CNT_W-1:0] phase;

  rps_phase_ctr #(.N_OUT(N_OUT), .CNT_W(CNT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slot_i  (slot_i),
    .phase_o (phase)
  );

  for (genvar o = 0; o < int'(N_OUT); o++) begin : g_lane
    rps_lane_sel #(
      .N_IN(N_IN), .N_OUT(N_OUT), .OUT_IDX(o),
      .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_sel (
      .phase_i   (phase),
      .in_vld_i  (in_vld_i),
      .in_tag_i  (in_tag_i),
      .in_data_i (in_data_i),
      .vld_o     (out_vld_o[o]),
      .tag_o     (out_tag_o[o*TAG_W +: TAG_W]),
      .data_o    (out_data_o[o*DATA_W +: DATA_W])
    );
  end

  assign phase_o = phase;
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_OUT  = 5,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = rps_pkg::phase_w(N_OUT)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    slot_i,
  input logic [N_IN-1:0]         in_vld_i,
  input logic [N_IN*TAG_W-1:0]   in_tag_i,
  input logic [N_IN*DATA_W-1:0]  in_data_i,
  input logic [N_OUT-1:0]        out_vld_o,
  input logic [N_OUT*TAG_W-1:0]  out_tag_o,
  input logic [N_OUT*DATA_W-1:0] out_data_o,
  input logic [CNT_W-1:0]        phase_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_OUT - 1);

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o <= LAST); // R2

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i && phase_o != LAST |=> phase_o == $past(phase_o) + CNT_W'(1)); // R2

  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i && phase_o == LAST |=> phase_o == '0); // R2

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> $stable(phase_o)); // R2

  AST_ONE_TO_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(out_vld_o) == $countones(in_vld_i)); // R4

  AST_LANE0_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o[phase_o] == in_vld_i[0]); // R3

  AST_LANE0_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_tag_o[phase_o*TAG_W +: TAG_W] == in_tag_i[TAG_W-1:0]); // R6

  AST_LANE0_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_data_o[phase_o*DATA_W +: DATA_W] == in_data_i[DATA_W-1:0]); // R6
endmodule

bind rot_perm_stage rps_checker #(
  .N_IN(N_IN), .N_OUT(N_OUT), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_rot_perm_stage.sv
`timescale 1ns/1ps
module sim_rot_perm_stage;
  localparam int NI = 4;
  localparam int NO = 5;
  localparam int TW = 4;
  localparam int DW = 8;
  localparam int CW = rps_pkg::phase_w(NO);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic slot_i = 1'b0;
  logic [NI-1:0]    in_vld_i = '0;
  logic [NI*TW-1:0] in_tag_i = '0;
  logic [NI*DW-1:0] in_data_i = '0;
  logic [NO-1:0]    out_vld_o;
  logic [NO*TW-1:0] out_tag_o;
  logic [NO*DW-1:0] out_data_o;
  logic [CW-1:0]    phase_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int exp_t = 0;

  always #2.5 clk_i = ~clk_i;

  rot_perm_stage #(.N_IN(NI), .N_OUT(NO), .TAG_W(TW), .DATA_W(DW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [NI-1:0] m, input int seed);
    in_vld_i = m;
    for (int g = 0; g < NI; g++) begin
      in_tag_i[g*TW +: TW]  = TW'(g * 3 + seed);
      in_data_i[g*DW +: DW] = DW'(seed * 16 + g + 1);
    end
  endtask

  // full port check against phase exp_t
  task automatic check_lanes(input string req);
    for (int o = 0; o < NO; o++) begin
      int g = (o - exp_t + NO) % NO;
      logic ev;
      logic [TW-1:0] et;
      logic [DW-1:0] ed;
      ev = 0; et = '0; ed = '0;
      if (g < NI) begin
        ev = in_vld_i[g];
        et = in_tag_i[g*TW +: TW];
        ed = in_data_i[g*DW +: DW];
      end
      chk(out_vld_o[o] == ev && out_tag_o[o*TW +: TW] == et && out_data_o[o*DW +: DW] == ed,
          req, {out_vld_o[o], out_tag_o[o*TW +: TW], out_data_o[o*DW +: DW]}, {ev, et, ed});
    end
  endtask

  task automatic step(input bit strobe);
    slot_i = strobe;
    @(posedge clk_i);
    #1 slot_i = 1'b0;
    if (strobe) exp_t = (exp_t + 1) % NO;
  endtask

  initial begin
    int visits[NI][NO];
    drive('1, 1);
    #1;
    chk(phase_o == '0, "R1 phase in reset", phase_o, 0);
    check_lanes("R1 identity in reset");
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #1 chk(phase_o == '0, "R1 phase after reset", phase_o, 0);

    // sweep all valid masks over two rotations: R3 R5 R6 R4
    for (int m = 0; m < (1 << NI); m++) begin
      for (int s = 0; s < 2 * NO; s++) begin
        @(negedge clk_i);
        drive(NI'(m), m + s);
        #1;
        check_lanes("R3/R5/R6 lane map");
        chk($countones(out_vld_o) == $countones(in_vld_i), "R4 one-to-one",
            $countones(out_vld_o), $countones(in_vld_i));
        step(1'b1);
      end
    end

    // R2: hold without strobe, then wrap
    @(negedge clk_i);
    for (int k = 0; k < 3; k++) step(1'b0);
    #1 chk(int'(phase_o) == exp_t, "R2 hold", phase_o, exp_t);
    while (exp_t != NO - 1) step(1'b1);
    #1 chk(int'(phase_o) == NO - 1, "R2 at last", phase_o, NO - 1);
    step(1'b1);
    #1 chk(phase_o == '0, "R2 wrap", phase_o, 0);

    // R7: each input visits each output once per rotation
    foreach (visits[g, o]) visits[g][o] = 0;
    for (int s = 0; s < NO; s++) begin
      @(negedge clk_i);
      for (int g = 0; g < NI; g++) begin
        drive(NI'(1 << g), 7);
        #1;
        for (int o = 0; o < NO; o++) if (out_vld_o[o]) visits[g][o]++;
      end
      step(1'b1);
    end
    foreach (visits[g, o]) chk(visits[g][o] == 1, "R7 visit count", visits[g][o], 1);

    // R1: reset mid-rotation restores phase 0
    step(1'b1); step(1'b1);
    @(negedge clk_i) rst_ni = 1'b0;
    exp_t = 0;
    drive('1, 9);
    #1 chk(phase_o == '0, "R1 mid-run reset", phase_o, 0);
    check_lanes("R1 identity after reset");
    @(negedge clk_i) rst_ni = 1'b1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule